// File: doc/BRIEF.md
# Paged Address Generator and Memory-Map Decoder

This block sits between an 8-bit processor core and its memory devices. It builds a 16-bit data address by placing a page byte above a low byte, the low byte being the 8-bit sum of a base register and an immediate. A memory-access request picks this data address over the program counter. The chosen address is then decoded into one of three devices: a ROM at the bottom of the space, a RAM directly above it, and a four-register I/O window at the very top. Everything else is unmapped.

For each access the block drives the device selects and the write strobes, and hands each device its local address. It packs the per-device valid flags into a status vector. It uses those flags to steer the byte from the one responding device back to the execute unit. Fetches and data accesses share the same decode, so the program counter can reach any mapped location. A registered flag marks accesses that hit the unmapped gap and stores aimed at ROM.

Top module: `mem_map_ctl`

## Requirements
- R1: With `mem_req`=1, `bus_addr` = {`page`, (`base`+`imm`) mod 256} in the same cycle. The carry out of the low-byte sum is dropped and never changes the page byte.
- R2: With `mem_req`=0, `bus_addr` equals `pc`.
- R3: `rom_sel` is 1 exactly when `bus_addr[15:12]`=0. `ram_sel` is 1 exactly when `bus_addr[15:12]`=1. `dev_addr` carries `bus_addr[11:0]`.
- R4: `io_sel` is 1 exactly when `bus_addr[15:2]` is all ones (0xFFFC..0xFFFF). `io_idx` carries `bus_addr[1:0]`.
- R5: Addresses 0x2000..0xFFFB assert no select.
- R6: A write happens only when `store` and `mem_req` are both 1. `ram_we` is that condition with `ram_sel`, and `io_we` is that condition with `io_sel`. A store into the ROM region raises no strobe.
- R7: `dev_valid` is {I/O, ROM, RAM} from bit 2 down to bit 0. The RAM bit and the I/O bit are set when their device is selected and no write happens. The ROM bit is set whenever ROM is selected.
- R8: `rd_data` is `io_rdata`, `rom_rdata` or `ram_rdata` for whichever `dev_valid` bit is set. It is 0x00 when no bit is set.
- R9: `map_fault` is high in the cycle after a clock edge at which the address was unmapped or a store hit ROM. Otherwise it is low, and it is 0 after reset.
- R10: `store` with `mem_req`=0 has no effect. The program-counter access is treated as a read: no strobe, and the selected device's valid bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | 16 | Program counter |
| page | input | 8 | Page byte (high address byte) |
| base | input | 8 | Base register value |
| imm | input | 8 | Immediate offset |
| mem_req | input | 1 | Data access request; selects the data address |
| store | input | 1 | Store qualifier |
| rom_rdata | input | 8 | ROM read byte |
| ram_rdata | input | 8 | RAM read byte |
| io_rdata | input | 8 | I/O read byte |
| bus_addr | output | 16 | Selected full address |
| dev_addr | output | 12 | Device-local address |
| io_idx | output | 2 | I/O register index |
| rom_sel | output | 1 | ROM select |
| ram_sel | output | 1 | RAM select |
| io_sel | output | 1 | I/O select |
| ram_we | output | 1 | RAM write strobe |
| io_we | output | 1 | I/O write strobe |
| dev_valid | output | 3 | Valid flags {io, rom, ram} |
| rd_data | output | 8 | Steered read byte |
| map_fault | output | 1 | Registered unmapped / ROM-store flag |

## Verification
The bench uses the default parameters: an 8-bit page, an 8-bit offset, a 4-bit region field and a 2-bit I/O index. With these values the edges of the map are easy to hit directly: 0x1FFF against 0x2000, and 0xFFFB against 0xFFFC. The same widths make the dropped carry visible whenever base plus immediate passes 255. The three devices return distinct constant bytes, so a wrong steering choice shows up in the returned byte.

// File: rtl/mem_map_ctl.sv
module mem_map_ctl #(
  parameter int PAGE_W     = 8,
  parameter int OFF_W      = 8,
  parameter int DATA_W     = 8,
  parameter int REGION_W   = 4,
  parameter int IO_W       = 2,
  parameter int ROM_REGION = 0,
  parameter int RAM_REGION = 1,
  localparam int ADDR_W    = PAGE_W + OFF_W,
  localparam int LOC_W     = ADDR_W - REGION_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  base,
  input  logic [OFF_W-1:0]  imm,
  input  logic              mem_req,
  input  logic              store,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LOC_W-1:0]  dev_addr,
  output logic [IO_W-1:0]   io_idx,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              io_sel,
  output logic              ram_we,
  output logic              io_we,
  output logic [2:0]        dev_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              map_fault
);
  logic [OFF_W-1:0]    low_sum;
  logic [REGION_W-1:0] region;
  logic                wr;

  assign low_sum  = base + imm;
  assign bus_addr = mem_req ? {page, low_sum} : pc;
  assign region   = bus_addr[ADDR_W-1 -: REGION_W];
  assign dev_addr = bus_addr[LOC_W-1:0];
  assign io_idx   = bus_addr[IO_W-1:0];

  assign rom_sel = (region == REGION_W'(ROM_REGION));
  assign ram_sel = (region == REGION_W'(RAM_REGION));
  assign io_sel  = &bus_addr[ADDR_W-1:IO_W];

  assign wr     = store & mem_req;
  assign ram_we = ram_sel & wr;
  assign io_we  = io_sel & wr;

  assign dev_valid = {io_sel & ~wr, rom_sel, ram_sel & ~wr};

  always_comb begin
    if (dev_valid[2])      rd_data = io_rdata;
    else if (dev_valid[1]) rd_data = rom_rdata;
    else if (dev_valid[0]) rd_data = ram_rdata;
    else                   rd_data = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) map_fault <= 1'b0;
    else        map_fault <= ~(rom_sel | ram_sel | io_sel) | (rom_sel & wr);
  end
endmodule

module mem_map_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              store,
  input logic              rom_sel,
  input logic              ram_sel,
  input logic              io_sel,
  input logic              ram_we,
  input logic              io_we,
  input logic [2:0]        dev_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              map_fault
);
  assert_sel_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_sel, rom_sel, ram_sel}));

  assert_ram_we_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_sel && store && mem_req));

  assert_io_we_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_we |-> (io_sel && store && mem_req));

  assert_no_valid_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store && mem_req) |-> (!dev_valid[0] && !dev_valid[2]));

  assert_rom_always_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> dev_valid[1]);

  assert_idle_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid == 3'b000) |-> (rd_data == '0));

  assert_unmapped_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel || ram_sel || io_sel) |=> map_fault);

  assert_rom_store_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && store && mem_req) |=> map_fault);
endmodule

bind mem_map_ctl mem_map_ctl_chk #(.DATA_W(DATA_W)) chk (.*);

// File: tb/mem_map_ctl_test.sv
module mem_map_ctl_test;
  localparam int PERIOD = 10;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  page = '0, base = '0, imm = '0;
  logic        mem_req = 1'b0, store = 1'b0;
  logic [7:0]  rom_rdata = 8'hA1, ram_rdata = 8'hB2, io_rdata = 8'hC3;
  logic [15:0] bus_addr;
  logic [11:0] dev_addr;
  logic [1:0]  io_idx;
  logic        rom_sel, ram_sel, io_sel, ram_we, io_we, map_fault;
  logic [2:0]  dev_valid;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mem_map_ctl uut (.*);

  // {pc, page, base, imm, mem_req, store}
  localparam logic [41:0] VIN [NV] = '{
    {16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    {16'h1234, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    {16'h5000, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    {16'hFFFE, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    {16'h0000, 8'h10, 8'h20, 8'h05, 1'b1, 1'b0},
    {16'h0000, 8'h10, 8'hF0, 8'h20, 1'b1, 1'b0},
    {16'h0000, 8'h10, 8'h80, 8'h7F, 1'b1, 1'b1},
    {16'h0000, 8'h03, 8'h00, 8'h44, 1'b1, 1'b1},
    {16'h0000, 8'hFF, 8'hFC, 8'h03, 1'b1, 1'b1},
    {16'h0000, 8'hFF, 8'hF0, 8'h0B, 1'b1, 1'b0},
    {16'h0000, 8'h1F, 8'hFF, 8'h00, 1'b1, 1'b0},
    {16'h0000, 8'h20, 8'h00, 8'h00, 1'b1, 1'b0},
    {16'h1100, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b1},
    {16'h0000, 8'hFF, 8'hFE, 8'h00, 1'b1, 1'b0}
  };

  // {bus_addr, sel{io,rom,ram}, we{io,ram}, valid{io,rom,ram}, fault}
  localparam logic [24:0] VEXP [NV] = '{
    {16'h0000, 3'b010, 2'b00, 3'b010, 1'b0},
    {16'h1234, 3'b001, 2'b00, 3'b001, 1'b0},
    {16'h5000, 3'b000, 2'b00, 3'b000, 1'b1},
    {16'hFFFE, 3'b100, 2'b00, 3'b100, 1'b0},
    {16'h1025, 3'b001, 2'b00, 3'b001, 1'b0},
    {16'h1010, 3'b001, 2'b00, 3'b001, 1'b0},
    {16'h10FF, 3'b001, 2'b01, 3'b000, 1'b0},
    {16'h0344, 3'b010, 2'b00, 3'b010, 1'b1},
    {16'hFFFF, 3'b100, 2'b10, 3'b000, 1'b0},
    {16'hFFFB, 3'b000, 2'b00, 3'b000, 1'b1},
    {16'h1FFF, 3'b001, 2'b00, 3'b001, 1'b0},
    {16'h2000, 3'b000, 2'b00, 3'b000, 1'b1},
    {16'h1100, 3'b001, 2'b00, 3'b001, 1'b0},
    {16'hFFFE, 3'b100, 2'b00, 3'b100, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] steer(input logic [2:0] v);
    if (v[2]) return 8'hC3;
    if (v[1]) return 8'hA1;
    if (v[0]) return 8'hB2;
    return 8'h00;
  endfunction

  initial begin
    #(PERIOD*5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pc = 16'h5000;
    repeat (3) @(posedge clk);
    #1 chk("R9 fault in reset", {31'd0, map_fault}, 32'd0);

    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {pc, page, base, imm, mem_req, store} = VIN[i];
      #1;
      chk(mem_req ? "R1 data address" : "R2 pc address", {16'd0, bus_addr}, {16'd0, VEXP[i][24:9]});
      chk("R3 local address", {20'd0, dev_addr}, {20'd0, VEXP[i][20:9]});
      chk("R4 io index", {30'd0, io_idx}, {30'd0, VEXP[i][10:9]});
      chk("R3 R4 R5 selects", {29'd0, io_sel, rom_sel, ram_sel}, {29'd0, VEXP[i][8:6]});
      chk("R6 R10 strobes", {30'd0, io_we, ram_we}, {30'd0, VEXP[i][5:4]});
      chk("R7 valid flags", {29'd0, dev_valid}, {29'd0, VEXP[i][3:1]});
      chk("R8 read steering", {24'd0, rd_data}, {24'd0, steer(VEXP[i][3:1])});
      @(posedge clk);
      #1 chk("R9 fault flag", {31'd0, map_fault}, {31'd0, VEXP[i][0]});
    end

    // R8: steering follows live device bytes
    @(negedge clk);
    {pc, mem_req, store} = {16'h0ABC, 1'b0, 1'b0};
    rom_rdata = 8'h5A; ram_rdata = 8'h00; io_rdata = 8'hFF;
    #1 chk("R8 rom byte passes", {24'd0, rd_data}, 32'h5A);
    pc = 16'hFFFC;
    #1 chk("R8 io byte passes", {24'd0, rd_data}, 32'hFF);

    // R9: reset clears a pending fault
    @(negedge clk) pc = 16'h8000;
    @(posedge clk);
    #1 chk("R9 fault set", {31'd0, map_fault}, 32'd1);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1 chk("R9 fault cleared by reset", {31'd0, map_fault}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule